// File: doc/BRIEF.md
# Upstream Legacy Interrupt Aggregator

This block holds the combined state of the four legacy interrupt lines (A, B, C, D) for the upstream port of one switch partition. It accepts virtual assert and deassert requests from the upstream port's own function and from a parameterised number of downstream ports. It moves each downstream request onto an upstream line by rotating the line index by the port's device number on the internal bus. It keeps one state bit for each source and upstream line.

The per-source bits are ORed into four aggregated lines. The block compares them with the line state last sent to the root complex. Where the two differ, it loads an Assert or Deassert message request into a registered output stage. A downstream consumer drains that stage with a ready/valid handshake. If several lines differ at once, they are issued lowest line first, one per cycle. Packet formatting and arbitration against other upstream traffic happen outside this block.

Top module: `intx_upstream_agg`

## Requirements
- R1: After reset every source/line state bit is negated and no message is offered (`msg_valid` low) until a request arrives.
- R2: When an upstream line that was last reported negated becomes asserted, the block offers a message with `msg_assert` = 1 for that line.
- R3: When an upstream line that was last reported asserted becomes negated, the block offers a message with `msg_assert` = 0 for that line.
- R4: An upstream line stays asserted while any source holds it. Negating one of several holders sends no message; only the last one to deassert causes a Deassert.
- R5: A source that repeats an assert on a line it already holds, or repeats a deassert on a line it does not hold, changes nothing, and no message results.
- R6: Requests from source 0 (the upstream port's own function) are not remapped: incoming line L stays upstream line L.
- R7: A request from downstream source k (1..N_DOWN) on incoming line L drives upstream line (L + DEV_FIRST + k - 1) mod 4. Its device number is DEV_FIRST + k - 1.
- R8: When several lines differ from their reported state at once, messages come out in line order A, B, C, D, one per accepted cycle.
- R9: An offered message keeps `msg_valid`, `msg_line` and `msg_assert` unchanged until it is accepted with `msg_ready` high at a clock edge.
- R10: If the output stage is empty, a request sampled at clock edge n shows up on the message outputs after edge n+1.
- R11: Line encoding on `req_line` and `msg_line` is 0 = A, 1 = B, 2 = C, 3 = D. On `req_assert` and `msg_assert`, 1 means assert and 0 means deassert.
- R12: A line change that is reversed before it is loaded into the output stage produces no message. Messages on one line always alternate Assert and Deassert, starting with Assert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_DOWN+1 | One request strobe per source; bit 0 is the upstream function |
| req_assert | input | N_DOWN+1 | Per source: 1 assert, 0 deassert |
| req_line | input | 2*(N_DOWN+1) | Per source incoming line, 2 bits each, source s at bits [2s+1:2s] |
| msg_valid | output | 1 | A message request is offered |
| msg_ready | input | 1 | Consumer accepts the offered message |
| msg_assert | output | 1 | 1 = Assert message, 0 = Deassert message |
| msg_line | output | 2 | Upstream line of the offered message |

## Verification
The assertions assume `msg_ready` is a known value at every edge and that each source raises at most one request per cycle, which the port shape already enforces. They also assume `rst` is held for at least one edge before traffic starts. The bench drives every input at the falling clock edge, holds reset for several cycles first, and never leaves an input undriven. Its random phase draws strobes, lines and ready from a linear feedback register, so every value it puts on the ports is a defined 0 or 1.

// File: rtl/intx_agg_pkg.sv
package intx_agg_pkg;

    localparam int NUM_LINES = 4;
    localparam int LINE_W    = 2;

    typedef logic [LINE_W-1:0]    line_t;
    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef struct packed {
        logic  valid;
        logic  is_assert;
        line_t line;
    } intx_msg_t;

    // Rotate an incoming line index by a device number (mod 4).
    function automatic line_t rotate_line(input line_t in_line, input int dev);
        line_t d;
        d = dev[LINE_W-1:0];
        return line_t'(in_line + d);
    endfunction

    // Lowest set index of a line vector; A has the highest priority.
    function automatic line_t lowest_set(input line_vec_t v);
        line_t r;
        r = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (v[i]) r = line_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/intx_src_state.sv
module intx_src_state
    import intx_agg_pkg::*;
#(
    parameter int NSRC      = 5,
    parameter int DEV_FIRST = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSRC-1:0]           req_valid,
    input  logic [NSRC-1:0]           req_assert,
    input  logic [NSRC*LINE_W-1:0]    req_line,
    output logic [NSRC*NUM_LINES-1:0] src_state
);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        line_t     in_line;
        line_t     up_line;
        line_vec_t st_q;

        assign in_line = req_line[s*LINE_W +: LINE_W];

        if (s == 0) begin : g_own
            // Upstream function: no bridge crossing, no rotation.
            assign up_line = in_line;
        end else begin : g_down
            localparam int DEV_NUM = DEV_FIRST + s - 1;
            assign up_line = rotate_line(in_line, DEV_NUM);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= '0;
            end else if (req_valid[s]) begin
                st_q[up_line] <= req_assert[s];
            end
        end

        assign src_state[s*NUM_LINES +: NUM_LINES] = st_q;
    end

endmodule

// File: rtl/intx_line_or.sv
module intx_line_or
    import intx_agg_pkg::*;
#(
    parameter int NSRC = 5
) (
    input  logic [NSRC*NUM_LINES-1:0] src_state,
    output line_vec_t                 agg_line
);

    always_comb begin
        agg_line = '0;
        for (int s = 0; s < NSRC; s++) begin
            agg_line = agg_line | src_state[s*NUM_LINES +: NUM_LINES];
        end
    end

endmodule

// File: rtl/intx_msg_issue.sv
module intx_msg_issue
    import intx_agg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t agg_line,
    input  logic      msg_ready,
    output intx_msg_t msg_q
);

    line_vec_t reported_q;
    line_vec_t pending;
    line_t     pick;
    logic      load_slot;

    assign pending   = agg_line ^ reported_q;
    assign pick      = lowest_set(pending);
    assign load_slot = !msg_q.valid || msg_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q      <= '0;
            reported_q <= '0;
        end else if (load_slot) begin
            if (|pending) begin
                msg_q.valid       <= 1'b1;
                msg_q.line        <= pick;
                msg_q.is_assert   <= agg_line[pick];
                reported_q[pick]  <= agg_line[pick];
            end else begin
                msg_q.valid       <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/intx_upstream_agg.sv
module intx_upstream_agg
    import intx_agg_pkg::*;
#(
    parameter int N_DOWN    = 4,
    parameter int DEV_FIRST = 1,
    localparam int NSRC     = N_DOWN + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC-1:0]        req_valid,
    input  logic [NSRC-1:0]        req_assert,
    input  logic [NSRC*LINE_W-1:0] req_line,
    output logic                   msg_valid,
    input  logic                   msg_ready,
    output logic                   msg_assert,
    output logic [LINE_W-1:0]      msg_line
);

    logic [NSRC*NUM_LINES-1:0] src_state;
    line_vec_t                 agg_line;
    intx_msg_t                 msg_q;

    intx_src_state #(
        .NSRC      (NSRC),
        .DEV_FIRST (DEV_FIRST)
    ) u_state (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_assert (req_assert),
        .req_line   (req_line),
        .src_state  (src_state)
    );

    intx_line_or #(
        .NSRC (NSRC)
    ) u_or (
        .src_state (src_state),
        .agg_line  (agg_line)
    );

    intx_msg_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .agg_line  (agg_line),
        .msg_ready (msg_ready),
        .msg_q     (msg_q)
    );

    assign msg_valid  = msg_q.valid;
    assign msg_assert = msg_q.is_assert;
    assign msg_line   = msg_q.line;

endmodule

// File: rtl/intx_agg_checker.sv
module intx_agg_checker
    import intx_agg_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic        msg_assert,
    input logic [1:0]  msg_line
);

    line_vec_t sent_q;
    logic      rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            sent_q <= '0;
        end else if (msg_valid && msg_ready) begin
            AST_ALTERNATE: assert (msg_assert != sent_q[msg_line]); // R12
            sent_q[msg_line] <= msg_assert;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_q) begin
            AST_QUIET_AFTER_RESET: assert (!msg_valid); // R1
        end
    end

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_line) && $stable(msg_assert))); // R9

    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({msg_valid, msg_assert, msg_line})); // R11

endmodule

bind intx_upstream_agg intx_agg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_assert (msg_assert),
    .msg_line   (msg_line)
);

// File: tb/intx_upstream_agg_test.sv
`timescale 1ns/1ps
module intx_upstream_agg_test;

    localparam int N_DOWN    = 4;
    localparam int DEV_FIRST = 1;
    localparam int NSRC      = N_DOWN + 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NSRC-1:0]      req_valid  = '0;
    logic [NSRC-1:0]      req_assert = '0;
    logic [NSRC*2-1:0]    req_line   = '0;
    logic                 msg_valid;
    logic                 msg_ready  = 1'b1;
    logic                 msg_assert;
    logic [1:0]           msg_line;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string tag    = "R1";

    // Scoreboard state, built from the requirements
    logic [3:0] m_st [NSRC];
    logic [3:0] m_rep;
    logic       m_ov, m_oa;
    logic [1:0] m_ol;

    always #2 clk = ~clk;

    intx_upstream_agg #(.N_DOWN(N_DOWN), .DEV_FIRST(DEV_FIRST)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_assert(req_assert),
        .req_line(req_line), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_assert(msg_assert), .msg_line(msg_line)
    );

    function automatic logic [1:0] up_of(input int src, input logic [1:0] l);
        if (src == 0) return l;
        return 2'((int'(l) + DEV_FIRST + src - 1) % 4);
    endfunction

    task automatic check(input bit ok, input string t, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NSRC; s++) m_st[s] = '0;
        m_rep = '0; m_ov = 0; m_oa = 0; m_ol = '0;
    endtask

    // One clock: advance model with the inputs held over the edge, compare.
    task automatic step();
        logic [3:0] agg, pend;
        @(negedge clk);
        agg = '0;
        for (int s = 0; s < NSRC; s++) agg = agg | m_st[s];
        if (!m_ov || msg_ready) begin
            pend = agg ^ m_rep;
            if (pend != 0) begin
                for (int i = 3; i >= 0; i--) if (pend[i]) m_ol = 2'(i);
                m_ov = 1; m_oa = agg[m_ol]; m_rep[m_ol] = agg[m_ol];
            end else begin
                m_ov = 0;
            end
        end
        for (int s = 0; s < NSRC; s++)
            if (req_valid[s]) m_st[s][up_of(s, req_line[2*s +: 2])] = req_assert[s];
        check(msg_valid === m_ov, tag, "msg_valid", int'(msg_valid), int'(m_ov));
        if (m_ov) begin
            check(msg_line === m_ol, tag, "msg_line", int'(msg_line), int'(m_ol));
            check(msg_assert === m_oa, tag, "msg_assert", int'(msg_assert), int'(m_oa));
        end
    endtask

    task automatic req(input int src, input logic a, input logic [1:0] l);
        req_valid[src] = 1'b1; req_assert[src] = a; req_line[2*src +: 2] = l;
    endtask

    task automatic clr();
        req_valid = '0;
    endtask

    task automatic expect_msg(input string t, input logic v, input logic [1:0] l, input logic a);
        check(msg_valid === v, t, "direct msg_valid", int'(msg_valid), int'(v));
        if (v) begin
            check(msg_line === l, t, "direct msg_line", int'(msg_line), int'(l));
            check(msg_assert === a, t, "direct msg_assert", int'(msg_assert), int'(a));
        end
    endtask

    task automatic idle(input int n);
        clr();
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        int unsigned lfsr = 32'hACE1_2468;
        model_reset();
        rst = 1'b1;
        for (int i = 0; i < 4; i++) @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        expect_msg("R1", 0, 0, 0);
        idle(3);
        expect_msg("R1", 0, 0, 0);

        // R6/R7/R2/R3/R10: sweep every source and incoming line
        for (int s = 0; s < NSRC; s++) begin
            for (int l = 0; l < 4; l++) begin
                tag = (s == 0) ? "R6" : "R7";
                req(s, 1'b1, 2'(l)); step();
                clr(); step();
                expect_msg((s == 0) ? "R6" : "R7", 1, up_of(s, 2'(l)), 1'b1);
                expect_msg("R2", 1, 2'(((s == 0 ? 0 : DEV_FIRST + s - 1) + l) % 4), 1'b1);
                step();
                expect_msg("R10", 0, 0, 0);
                req(s, 1'b0, 2'(l)); step();
                clr(); step();
                expect_msg("R3", 1, up_of(s, 2'(l)), 1'b0);
                idle(1);
            end
        end

        // R4: two holders of upstream line A (src0 line A, src4 line A -> +0)
        tag = "R4";
        req(0, 1, 0); req(4, 1, 0); step(); idle(3);
        req(0, 0, 0); step(); clr(); step();
        expect_msg("R4", 0, 0, 0);
        idle(2);
        expect_msg("R4", 0, 0, 0);
        req(4, 0, 0); step(); clr(); step();
        expect_msg("R4", 1, 0, 0);
        idle(2);

        // R5: repeated assert / deassert from one source
        tag = "R5";
        req(0, 1, 2); step(); req(0, 1, 2); step();
        expect_msg("R5", 1, 2, 1);
        clr(); step();
        expect_msg("R5", 0, 0, 0);
        idle(2);
        expect_msg("R5", 0, 0, 0);
        req(0, 0, 2); step(); req(0, 0, 2); step();
        expect_msg("R5", 1, 2, 0);
        clr(); step();
        expect_msg("R5", 0, 0, 0);
        req(0, 0, 2); step(); clr(); step(); step();
        expect_msg("R5", 0, 0, 0);

        // R8: four lines change together, issued A,B,C,D
        tag = "R8";
        req(0, 1, 0); req(1, 1, 0); req(2, 1, 0); req(3, 1, 0); step();
        clr(); step();
        for (int i = 0; i < 4; i++) begin
            expect_msg("R8", 1, 2'(i), 1'b1);
            step();
        end
        expect_msg("R8", 0, 0, 0);
        req(3, 0, 0); req(2, 0, 0); req(1, 0, 0); req(0, 0, 0); step();
        clr(); step();
        for (int i = 0; i < 4; i++) begin
            expect_msg("R8", 1, 2'(i), 1'b0);
            step();
        end

        // R9: message held while ready is low
        tag = "R9";
        msg_ready = 0;
        req(0, 1, 1); step(); clr(); step();
        for (int i = 0; i < 5; i++) begin
            expect_msg("R9", 1, 1, 1);
            step();
        end
        msg_ready = 1; step();
        expect_msg("R9", 0, 0, 0);
        req(0, 0, 1); step(); idle(3);

        // R12: change reverted while output stage is busy
        tag = "R12";
        msg_ready = 0;
        req(0, 1, 0); step();
        req(0, 1, 1); step();
        req(0, 0, 1); step();
        clr(); msg_ready = 1; step();
        expect_msg("R12", 0, 0, 0);
        req(0, 0, 0); step(); idle(3);

        // R11: pseudo-random traffic against the scoreboard
        tag = "R11";
        for (int c = 0; c < 4000; c++) begin
            for (int s = 0; s < NSRC; s++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                req_valid[s]  = (lfsr[3:2] == 2'b00);
                req_assert[s] = lfsr[7];
                req_line[2*s +: 2] = lfsr[12:11];
            end
            msg_ready = lfsr[17] | lfsr[19];
            step();
        end
        msg_ready = 1;
        idle(12);
        expect_msg("R11", 0, 0, 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule